// File: doc/BRIEF.md
# Shared Interrupt Distribution Unit

This unit sits between a set of shared, level-triggered interrupt sources and several processor cores. Each shared source has its own configuration: a destination core mask, a distribution mode and a mask bit. A source is delivered either to one fixed core or in rotation among the cores in its destination mask, where each new assertion moves to the next eligible core. Delivery starts only after a global enable command.

Configuration arrives as single-cycle commands. Each command carries an opcode, a source index and a 32-bit data word, and it takes effect at the clock edge where `cmd_valid` is high. The outputs form one group of uplink lines per core, with one line per shared source. Source `k` always lands on line `k` of the chosen core's group, so each core sees the shared sources as a contiguous block of interrupt numbers. The path from a source input to its uplink is combinational, so an uplink rises and falls in the same cycle as its source.

Top module: `irq_dist_unit`

## Requirements
- R1: After reset every source is masked, the global enable is off and every destination mask is zero, so all of `core_irq` is 0 even while sources are high.
- R2: No uplink is driven until an enable command (`cmd_op` = 4) has been accepted. The enable then stays on until reset.
- R3: Opcodes: 1 writes `cmd_data[NUM_CORES-1:0]` as the destination mask of source `cmd_idx` (bit c = core c), 2 writes the mode word, 3 writes the mask bit, 4 sets the global enable. A command changes outputs from the cycle after its accepting edge.
- R4: A mask command with `cmd_data[0]` = 1 masks the source and with 0 unmasks it. A masked source drives no uplink.
- R5: Mode bits [1:0] = 00 select round-robin. Any other value selects fixed destination. All other mode bits, including the level-select bit 4, have no effect on routing.
- R6: In fixed mode exactly one core, the lowest set bit of the destination mask, receives the source.
- R7: In round-robin mode each new assertion goes to the next set bit of the destination mask after the core served last, wrapping around. The first assertion after reset goes to the lowest set bit. The chosen core holds while the request stays high.
- R8: Source k served by core c drives `core_irq[c*NUM_SRC + k]`.
- R9: The uplink rises and falls in the same cycle as the source input.
- R10: At any time a source drives at most one uplink.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | $clog2(NUM_SRC) | Source index the command applies to |
| cmd_data | input | 32 | Command data word |
| src_irq | input | NUM_SRC | Shared level interrupt inputs |
| core_irq | output | NUM_CORES*NUM_SRC | Per-core uplink groups, line c*NUM_SRC+k |

## Verification
Routing results are due in the same cycle as a source change. The bench therefore drives each source pattern just after a falling edge and samples the outputs a couple of nanoseconds later, before the next rising edge. That rising edge updates the rotation state, so the next pattern's expected value already reflects that update. Configuration results are due one cycle after the command. The bench checks the output both in the cycle the mask command is pending, where the old value still holds, and in the cycle after, where the source has dropped.

// File: rtl/idu_pkg.sv
package idu_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_DEST   = 3'd1,
    OP_MODE   = 3'd2,
    OP_MASK   = 3'd3,
    OP_ENABLE = 3'd4
  } idu_op_e;

  localparam logic [1:0] DISTR_RR = 2'b00;

  // First set bit of dest strictly after position last, circular over n
  // cores. Returns n when dest has no set bit below n.
  function automatic int next_core(input logic [31:0] dest, input int last,
                                   input int n);
    int res;
    int idx;
    logic found;
    res   = n;
    found = 1'b0;
    for (int i = 1; i <= 32; i++) begin
      if (i <= n && !found) begin
        idx = last + i;
        if (idx >= n) idx = idx - n;
        if (dest[idx]) begin
          res   = idx;
          found = 1'b1;
        end
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/idu_cfg_regs.sv
module idu_cfg_regs
  import idu_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int NUM_CORES = 4,
  parameter int IDXW      = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cmd_valid,
  input  logic [2:0]                           cmd_op,
  input  logic [IDXW-1:0]                      cmd_idx,
  input  logic [31:0]                          cmd_data,
  output logic                                 en_q,
  output logic [NUM_SRC-1:0]                   mask_q,
  output logic [NUM_SRC-1:0]                   rr_q,
  output logic [NUM_SRC-1:0][NUM_CORES-1:0]    dest_q
);

  logic unused_bits;
  assign unused_bits = ^cmd_data[31:NUM_CORES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '1;
      rr_q   <= '0;
      dest_q <= '0;
    end else if (cmd_valid && int'(cmd_idx) < NUM_SRC) begin
      case (idu_op_e'(cmd_op))
        OP_DEST:   dest_q[cmd_idx] <= cmd_data[NUM_CORES-1:0];
        OP_MODE:   rr_q[cmd_idx]   <= (cmd_data[1:0] == DISTR_RR);
        OP_MASK:   mask_q[cmd_idx] <= cmd_data[0];
        OP_ENABLE: en_q            <= 1'b1;
        default:   ;
      endcase
    end
  end

  // R2: once on, the enable never drops outside reset
  a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

endmodule

// File: rtl/idu_src_route.sv
module idu_src_route
  import idu_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 rr_mode,
  input  logic [NUM_CORES-1:0] dest,
  output logic [NUM_CORES-1:0] grant
);

  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic          held_q;
  logic [CW-1:0] cur_q;
  logic [CW-1:0] last_q;
  int            pick_idx;
  logic          pick_ok;
  logic          new_assert;

  always_comb begin
    if (rr_mode) pick_idx = next_core(32'(dest), int'(last_q), NUM_CORES);
    else         pick_idx = next_core(32'(dest), NUM_CORES - 1, NUM_CORES);
    pick_ok = (pick_idx < NUM_CORES);
  end

  assign new_assert = req && !held_q && pick_ok;

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      grant[c] = req && (held_q ? (int'(cur_q) == c)
                                : (pick_ok && pick_idx == c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      cur_q  <= '0;
      last_q <= CW'(NUM_CORES - 1);
    end else if (!req) begin
      held_q <= 1'b0;
    end else if (new_assert) begin
      held_q <= 1'b1;
      cur_q  <= CW'(pick_idx);
      if (rr_mode) last_q <= CW'(pick_idx);
    end
  end

  // R10: never more than one core per source
  a_r10_single_core: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7: the chosen core holds while the request stays high
  a_r7_hold_choice: assert property (@(posedge clk) disable iff (!rst_n)
    (req && $past(req) && $past(grant) != '0) |-> grant == $past(grant));

endmodule

// File: rtl/irq_dist_unit.sv
module irq_dist_unit
  import idu_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int NUM_CORES = 4,
  localparam int IDXW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [2:0]                     cmd_op,
  input  logic [IDXW-1:0]                cmd_idx,
  input  logic [31:0]                    cmd_data,
  input  logic [NUM_SRC-1:0]             src_irq,
  output logic [NUM_CORES*NUM_SRC-1:0]   core_irq
);

  logic                              en_q;
  logic [NUM_SRC-1:0]                mask_q;
  logic [NUM_SRC-1:0]                rr_q;
  logic [NUM_SRC-1:0][NUM_CORES-1:0] dest_q;
  logic [NUM_SRC-1:0]                req;
  logic [NUM_SRC-1:0][NUM_CORES-1:0] grant;

  idu_cfg_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .IDXW(IDXW)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .en_q(en_q), .mask_q(mask_q),
    .rr_q(rr_q), .dest_q(dest_q)
  );

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign req[k] = src_irq[k] && !mask_q[k] && en_q;

    idu_src_route #(.NUM_CORES(NUM_CORES)) i_route (
      .clk(clk), .rst_n(rst_n), .req(req[k]), .rr_mode(rr_q[k]),
      .dest(dest_q[k]), .grant(grant[k])
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign core_irq[c*NUM_SRC + k] = grant[k][c];
    end

    // R4: a masked source reaches no core
    a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[k] |-> grant[k] == '0);
  end

  // R2: nothing is routed while the enable is off
  a_r2_no_route_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> core_irq == '0);

endmodule

// File: tb/test_irq_dist_unit.sv
module test_irq_dist_unit;

  localparam int NS = 4;
  localparam int NC = 4;
  localparam int NV = 11;

  // {src_irq, expected core_irq}; config is set up before the walk
  localparam logic [19:0] VEC [NV] = '{
    {4'b0001, 16'h0100},  // R6 src0 fixed -> core2, line 8 (R8)
    {4'b0011, 16'h0102},  // R7 src1 first rr -> core0
    {4'b0011, 16'h0102},  // R7 hold while high
    {4'b0001, 16'h0100},  // R9 drop same cycle
    {4'b0010, 16'h0020},  // R7 next -> core1
    {4'b0000, 16'h0000},  // R9
    {4'b0010, 16'h2000},  // R7 next -> core3
    {4'b0000, 16'h0000},
    {4'b0010, 16'h0002},  // R7 wrap -> core0
    {4'b1100, 16'h0040},  // R6 src2 lowest of 1010 -> core1, R4 src3 masked
    {4'b0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_idx = '0;
  logic [31:0] cmd_data = '0;
  logic [NS-1:0] src_irq = '0;
  logic [NC*NS-1:0] core_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_dist_unit #(.NUM_SRC(NS), .NUM_CORES(NC)) i_irq_dist_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .src_irq(src_irq),
    .core_irq(core_irq)
  );

  task automatic check(input string req, input logic [NC*NS-1:0] exp);
    checks++;
    if (core_irq !== exp) begin
      errors++;
      $display("FAIL %s: core_irq=%h expected %h", req, core_irq, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int idx, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = 2'(idx); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drive(input logic [NS-1:0] s);
    @(negedge clk);
    src_irq = s;
    #2;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    src_irq = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 reset state", '0);

    // R3 configuration
    cmd(3'd1, 0, 32'h4);           // src0 dest core2
    cmd(3'd1, 1, 32'hB);           // src1 dest cores 0,1,3
    cmd(3'd1, 2, 32'hA);           // src2 dest cores 1,3
    cmd(3'd1, 3, 32'hF);
    cmd(3'd2, 0, 32'hFFFF_FFF1);   // fixed, junk upper bits (R5)
    cmd(3'd2, 1, 32'h0000_0010);   // round-robin, level bit set
    cmd(3'd2, 2, 32'h0000_0013);   // distr 11 -> fixed (R5)
    cmd(3'd2, 3, 32'h0000_0011);
    cmd(3'd3, 0, 32'h0);
    cmd(3'd3, 1, 32'h0);
    cmd(3'd3, 2, 32'h0);
    #2;
    check("R2 no routing before enable", '0);
    drive('0);
    cmd(3'd4, 0, 32'h0);
    #2;
    check("R2 enabled with idle sources", '0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:16]);
      check($sformatf("R7/R8 vector %0d", i), VEC[i][15:0]);
    end

    // R4 unmask src3, fixed lowest of 1111 -> core0 line 3
    cmd(3'd3, 3, 32'h0);
    drive(4'b1000);
    check("R4 unmasked src3 to core0", 16'h0008);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_idx = 2'd3; cmd_data = 32'h1;
    #2;
    check("R4 mask pending, old value", 16'h0008);
    @(negedge clk);
    cmd_valid = 1'b0;
    #2;
    check("R4 masked src3 silent", 16'h0000);
    drive('0);

    // R5 other mode bits ignored: still round-robin, last was core0
    cmd(3'd2, 1, 32'hFFFF_FFEC);
    drive(4'b0010);
    check("R5 rr kept, next core1", 16'h0020);
    drive('0);
    cmd(3'd2, 1, 32'h0000_0002);
    drive(4'b0010);
    check("R6 fixed lowest of 1011 core0", 16'h0002);
    drive(4'b0010);
    check("R6 fixed holds", 16'h0002);
    drive('0);
    check("R9 release", 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule